// File: doc/BRIEF.md
# Serial Auto-Baud Rate Detector

This block calibrates a serial link to an unknown host bit rate. While a host repeatedly sends zero bytes (8 data bits, 1 stop bit, no parity) on an idle-high receive line, the block counts how many system clock cycles each low stretch lasts. A zero byte holds the line low for nine bit times: the start bit and eight zero data bits. The bit-period divisor is therefore the low-run length divided by nine, rounded to the nearest integer.

Calibration begins with a one-cycle arm strobe. A low run is accepted only if it falls inside the window spanned by the three supported host rates (2400, 4800 and 9600 bit/s), with a margin on both sides. Once two consecutive accepted runs agree closely, the divisor is loaded into the output register and the block locks. It also pulses a request for the transmit side to send a single zero byte back to the host as confirmation. The lock holds until reset, and the divisor then feeds the serial receiver and transmitter.

Top module: `auto_baud_detect`

## Requirements
- R1: After reset, baud_div is 0 and locked, rate_err and echo_req are all 0.
- R2: The receive line is ignored until arm is pulsed. A low run counts only if its falling edge is seen after arming, so a run that was already under way when arm arrived is not measured.
- R3: A run's length is the number of clock cycles the line stays low. At lock, baud_div is loaded with floor((len + 4) / 9), where len is the second run of the agreeing pair.
- R4: Lock requires two consecutive accepted runs a (earlier) and b (later) with |a − b| × 100 ≤ 3 × a. If they disagree, b becomes the new reference and the block waits for the next run.
- R5: A run is rejected when it is shorter than floor(floor(9·CLK_HZ/9600) × 90 / 100) or longer than floor(floor(9·CLK_HZ/2400) × 110 / 100). A rejected run sets rate_err, is discarded, and clears any pending reference.
- R6: rate_err stays set until the next arm pulse that arrives while unlocked, or until reset.
- R7: Once locked, locked stays 1 until reset. After lock, baud_div and rate_err do not change, whatever happens on the receive line or on arm.
- R8: echo_req is a single-cycle pulse, issued exactly once, in the same cycle that locked rises.
- R9: Host rates of 2400, 4800 and 9600 bit/s each lead to lock with the divisor given in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial receive line, idle high, asynchronous |
| arm | input | 1 | One-cycle strobe that starts or restarts calibration |
| baud_div | output | LEN_W | Bit-period divisor in clock cycles |
| locked | output | 1 | Calibration complete, held until reset |
| rate_err | output | 1 | A low run fell outside the supported window |
| echo_req | output | 1 | One-cycle request to send a single zero byte back |

## Verification
The hardest case to reach from the ports is arming in the middle of a low run. If that partial run were measured, it would be out of range and would raise rate_err. The stimulus therefore holds the line low, pulses arm partway through the run, and only then releases the line. It then checks that neither an error nor a lock follows until two complete frames have passed. The tolerance edge is reached by pairing runs whose difference lies just inside the 3% limit, and by pairing runs whose difference lies well outside it.

// File: rtl/abd_pkg.sv
package abd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_MEASURE,
      ST_DIVIDE,
      ST_LOCKED
   } abd_state_e;

   // clock cycles covered by a run of 'bits' bit times at 'rate' bit/s
   function automatic longint run_cycles(longint clk_hz, longint rate, longint bits);
      return (bits * clk_hz) / rate;
   endfunction
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d} ;
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/abd_run_timer.sv
module abd_run_timer #(
   parameter int LEN_W   = 10,
   parameter int SAT_LEN = 991
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             line,
   output logic             len_valid,
   output logic [LEN_W-1:0] len
);
   logic             prev_line;
   logic             in_run;
   logic [LEN_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_line <= 1'b1;
         in_run    <= 1'b0;
         cnt       <= '0;
         len_valid <= 1'b0;
         len       <= '0;
      end else begin
         prev_line <= line;
         len_valid <= 1'b0;
         if (!en) begin
            in_run <= 1'b0;
            cnt    <= '0;
         end else if (prev_line && !line) begin
            in_run <= 1'b1;
            cnt    <= LEN_W'(1);
         end else if (in_run && !line) begin
            if (cnt != LEN_W'(SAT_LEN)) cnt <= cnt + LEN_W'(1);
         end else if (in_run && line) begin
            in_run    <= 1'b0;
            len_valid <= 1'b1;
            len       <= cnt;
         end
      end
   end
endmodule

// File: rtl/abd_const_div.sv
module abd_const_div #(
   parameter int NW  = 10,
   parameter int DEN = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [NW-1:0] num,
   output logic          done,
   output logic [NW-1:0] quo
);
   localparam int CW = $clog2(NW + 1);

   logic [NW-1:0] rem;
   logic [CW-1:0] steps;
   logic          busy;
   logic [NW:0]   trial;
   logic          take;

   assign trial = {rem, quo[NW-1]};
   assign take  = trial >= (NW+1)'(DEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem   <= '0;
         quo   <= '0;
         steps <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            quo   <= num;
            rem   <= '0;
            steps <= CW'(NW);
            busy  <= 1'b1;
         end else if (busy) begin
            rem   <= take ? NW'(trial - (NW+1)'(DEN)) : NW'(trial);
            quo   <= {quo[NW-2:0], take};
            steps <= steps - CW'(1);
            if (steps == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/auto_baud_detect.sv
module auto_baud_detect
   import abd_pkg::*;
#(
   parameter int CLK_HZ      = 50_000_000,
   parameter int RATE_SLOW   = 2400,
   parameter int RATE_FAST   = 9600,
   parameter int LOW_BITS    = 9,
   parameter int MARGIN_PCT  = 10,
   parameter int TOL_PCT     = 3,
   parameter int SYNC_STAGES = 2,
   localparam int RUN_FAST = int'(run_cycles(CLK_HZ, RATE_FAST, LOW_BITS)),
   localparam int RUN_SLOW = int'(run_cycles(CLK_HZ, RATE_SLOW, LOW_BITS)),
   localparam int MIN_LOW  = RUN_FAST * (100 - MARGIN_PCT) / 100,
   localparam int MAX_LOW  = int'((longint'(RUN_SLOW) * (100 + MARGIN_PCT)) / 100),
   localparam int LEN_W    = $clog2(MAX_LOW + LOW_BITS + 2),
   localparam int DIV_LO   = (MIN_LOW + LOW_BITS / 2) / LOW_BITS,
   localparam int DIV_HI   = (MAX_LOW + LOW_BITS / 2) / LOW_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_line,
   input  logic             arm,
   output logic [LEN_W-1:0] baud_div,
   output logic             locked,
   output logic             rate_err,
   output logic             echo_req
);
   localparam int PROD_W = LEN_W + 8;

   generate
      if (RATE_FAST <= RATE_SLOW) begin : g_bad_rates
         $error("RATE_FAST must exceed RATE_SLOW");
      end
      if (MARGIN_PCT >= 100 || TOL_PCT >= 100) begin : g_bad_pct
         $error("percent parameters must be below 100");
      end
      if (MIN_LOW < 2 || LEN_W < 3) begin : g_bad_clock
         $error("clock too slow for the fastest rate");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..4");
      end
   endgenerate

   abd_state_e       st;
   logic             line_s;
   logic             len_valid;
   logic [LEN_W-1:0] len;
   logic [LEN_W-1:0] ref_len;
   logic             have_ref;
   logic [LEN_W-1:0] diff;
   logic [PROD_W-1:0] lhs, rhs;
   logic             in_range, agree;
   logic             div_start, div_done;
   logic [LEN_W-1:0] div_num, quo;

   abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rx_line), .q(line_s)
   );

   abd_run_timer #(.LEN_W(LEN_W), .SAT_LEN(MAX_LOW + 1)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(st == ST_MEASURE), .line(line_s),
      .len_valid(len_valid), .len(len)
   );

   abd_const_div #(.NW(LEN_W), .DEN(LOW_BITS)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
      .done(div_done), .quo(quo)
   );

   assign diff     = (len > ref_len) ? len - ref_len : ref_len - len;
   assign lhs      = PROD_W'(diff) * PROD_W'(100);
   assign rhs      = PROD_W'(ref_len) * PROD_W'(TOL_PCT);
   assign agree    = have_ref && (lhs <= rhs);
   assign in_range = (len >= LEN_W'(MIN_LOW)) && (len <= LEN_W'(MAX_LOW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ref_len   <= '0;
         have_ref  <= 1'b0;
         rate_err  <= 1'b0;
         baud_div  <= '0;
         locked    <= 1'b0;
         echo_req  <= 1'b0;
         div_start <= 1'b0;
         div_num   <= '0;
      end else begin
         echo_req  <= 1'b0;
         div_start <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (arm) begin
                  st       <= ST_MEASURE;
                  rate_err <= 1'b0;
                  have_ref <= 1'b0;
               end
            end
            ST_MEASURE: begin
               if (arm) begin
                  rate_err <= 1'b0;
                  have_ref <= 1'b0;
               end else if (len_valid) begin
                  if (!in_range) begin
                     rate_err <= 1'b1;
                     have_ref <= 1'b0;
                  end else if (agree) begin
                     div_num   <= len + LEN_W'(LOW_BITS / 2);
                     div_start <= 1'b1;
                     st        <= ST_DIVIDE;
                  end else begin
                     ref_len  <= len;
                     have_ref <= 1'b1;
                  end
               end
            end
            ST_DIVIDE: begin
               if (div_done) begin
                  baud_div <= quo;
                  locked   <= 1'b1;
                  echo_req <= 1'b1;
                  st       <= ST_LOCKED;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/auto_baud_detect_chk.sv
module auto_baud_detect_chk #(
   parameter int LEN_W  = 10,
   parameter int DIV_LO = 1,
   parameter int DIV_HI = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             arm,
   input logic [LEN_W-1:0] baud_div,
   input logic             locked,
   input logic             rate_err,
   input logic             echo_req
);
   a_r7_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
   a_r7_div_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(baud_div));
   a_r7_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(rate_err));
   a_r8_echo_at_lock: assert property (@(posedge clk) disable iff (!rst_n)
      echo_req |-> $rose(locked));
   a_r8_lock_gives_echo: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> echo_req);
   a_r3_div_window: assert property (@(posedge clk) disable iff (!rst_n)
      locked |-> (baud_div >= LEN_W'(DIV_LO) && baud_div <= LEN_W'(DIV_HI)));
   a_r6_err_clear_by_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rate_err) |-> $past(arm));
endmodule

bind auto_baud_detect auto_baud_detect_chk #(
   .LEN_W(LEN_W), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)
) u_chk (
   .clk(clk), .rst_n(rst_n), .arm(arm), .baud_div(baud_div),
   .locked(locked), .rate_err(rate_err), .echo_req(echo_req)
);

// File: tb/auto_baud_detect_test.sv
module auto_baud_detect_test;
   localparam int CLK_HZ = 240_000;   // 9600 bit/s -> 25 cycles per bit
   localparam int LEN_W  = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_line = 1'b1;
   logic             arm = 1'b0;
   logic [LEN_W-1:0] baud_div;
   logic             locked, rate_err, echo_req;

   int checks = 0;
   int errors = 0;
   int echo_cnt = 0;

   always #5 clk = ~clk;

   auto_baud_detect #(.CLK_HZ(CLK_HZ)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .arm(arm),
      .baud_div(baud_div), .locked(locked), .rate_err(rate_err),
      .echo_req(echo_req)
   );

   always @(negedge clk) if (rst_n && echo_req) echo_cnt++;

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_div(int len);
      return (len + 4) / 9;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; rx_line = 1'b1; arm = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      echo_cnt = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic pulse_arm();
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
   endtask

   task automatic frame(int low, int high);
      rx_line = 1'b0;
      repeat (low) @(negedge clk);
      rx_line = 1'b1;
      repeat (high) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      check("R1", "baud_div", int'(baud_div), 0);
      check("R1", "locked", int'(locked), 0);
      check("R1", "rate_err", int'(rate_err), 0);
      check("R1", "echo_req", int'(echo_req), 0);
   endtask

   task automatic t_unarmed();
      do_reset();
      repeat (3) frame(225, 25);
      frame(100, 25);
      repeat (40) @(negedge clk);
      check("R2", "locked without arm", int'(locked), 0);
      check("R2", "rate_err without arm", int'(rate_err), 0);
   endtask

   task automatic t_rate(int bit_cyc, string tag);
      do_reset();
      pulse_arm();
      repeat (2) frame(9 * bit_cyc, bit_cyc);
      repeat (40) @(negedge clk);
      check(tag, "locked", int'(locked), 1);
      check("R3", "baud_div", int'(baud_div), exp_div(9 * bit_cyc));
      check("R8", "echo pulses", echo_cnt, 1);
      check("R9", "rate_err", int'(rate_err), 0);
   endtask

   task automatic t_range();
      do_reset();
      pulse_arm();
      frame(150, 25);
      repeat (10) @(negedge clk);
      check("R5", "short run sets rate_err", int'(rate_err), 1);
      frame(225, 25);
      frame(1000, 25);
      repeat (10) @(negedge clk);
      check("R5", "long run discarded, no lock", int'(locked), 0);
      repeat (2) frame(450, 50);
      repeat (40) @(negedge clk);
      check("R5", "lock after rejects", int'(locked), 1);
      check("R5", "divisor", int'(baud_div), exp_div(450));
      check("R6", "rate_err held", int'(rate_err), 1);
      // clearing by arm while unlocked
      do_reset();
      pulse_arm();
      frame(150, 25);
      repeat (5) @(negedge clk);
      pulse_arm();
      repeat (2) @(negedge clk);
      check("R6", "rate_err cleared by arm", int'(rate_err), 0);
   endtask

   task automatic t_tolerance();
      do_reset();
      pulse_arm();
      frame(225, 25);
      frame(240, 25);
      repeat (40) @(negedge clk);
      check("R4", "no lock on 6.7% mismatch", int'(locked), 0);
      frame(240, 25);
      repeat (40) @(negedge clk);
      check("R4", "lock on new reference", int'(locked), 1);
      check("R4", "divisor from second run", int'(baud_div), exp_div(240));
      do_reset();
      pulse_arm();
      frame(225, 25);
      frame(231, 25);
      repeat (40) @(negedge clk);
      check("R4", "lock inside 3%", int'(locked), 1);
      check("R3", "divisor uses later run", int'(baud_div), exp_div(231));
   endtask

   task automatic t_after_lock();
      do_reset();
      pulse_arm();
      repeat (2) frame(225, 25);
      repeat (40) @(negedge clk);
      pulse_arm();
      frame(120, 25);
      repeat (3) frame(900, 100);
      pulse_arm();
      repeat (20) @(negedge clk);
      check("R7", "locked held", int'(locked), 1);
      check("R7", "divisor frozen", int'(baud_div), exp_div(225));
      check("R7", "rate_err unchanged", int'(rate_err), 0);
      check("R8", "single echo", echo_cnt, 1);
   endtask

   task automatic t_mid_low();
      do_reset();
      rx_line = 1'b0;
      repeat (100) @(negedge clk);
      pulse_arm();
      repeat (124) @(negedge clk);
      rx_line = 1'b1;
      repeat (25) @(negedge clk);
      frame(225, 25);
      repeat (40) @(negedge clk);
      check("R2", "partial run not measured (err)", int'(rate_err), 0);
      check("R2", "partial run not measured (lock)", int'(locked), 0);
      frame(225, 25);
      repeat (40) @(negedge clk);
      check("R2", "lock on two full runs", int'(locked), 1);
      check("R3", "divisor", int'(baud_div), exp_div(225));
   endtask

   initial begin
      t_reset();
      t_unarmed();
      t_rate(25, "R9");
      t_rate(50, "R9");
      t_rate(100, "R9");
      t_range();
      t_tolerance();
      t_after_lock();
      t_mid_low();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150_000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule